// File: doc/BRIEF.md
# TDM Receive Channel Switch

This block is the receive side of a time-slot switch for a group of receive channels. A frame holds a fixed number of byte-wide timeslots. Each timeslot lasts one clock cycle and is marked by a slot index, and a one-cycle frame sync marks slot 0. Every timeslot carries one byte on each of several parallel streams. Each receive channel produces one byte per frame.

A channel gets its byte from one of three places. It can take a routed bus timeslot and stream. With local connect set, it can take a transmit channel's sample straight from the transmit sample array. Or the host can write the byte into the channel's parallel register.

Each channel has a small register set on a simple host bus: control, two routing bytes, the parallel register and a status byte. The control register picks between frame-aligned switching with a fixed one-frame delay and minimum-delay switching. Minimum-delay switching hands data over at the channel's own output slot. Channel `c` delivers at output slot `c`. Each channel's output passes through an output enable, and its valid flag shows that the channel has handed over at least one sample.

Top module: `tdm_rx_switch`

## Requirements
- R1: After reset, every register of every channel reads 0, every `rx_valid` bit is 0 and every `rx_data` byte is 0xFF.
- R2: The register select is `host_addr[2:0]`: 0 control, 1 routing byte A, 2 routing byte B, 3 parallel register, 4 status. The channel number is in the upper address bits. In the control register, bit 0 selects minimum delay, bit 1 selects local connect and bit 2 selects the parallel source. Control bits [7:3] always read 0, whatever was written to them.
- R3: With the serial source and local connect off, the channel captures `bus_in` stream `B[0]` in the cycle where `slot_idx` equals routing byte A.
- R4: In constant mode, the channel output takes the captured byte at the frame-sync edge. A byte captured in frame F therefore appears for the whole of frame F+1.
- R5: In minimum-delay mode, channel `c` hands over at the edge where `slot_idx == c`. At the end of frame F its output holds the frame-F byte when the input slot is below `c`, and the frame F-1 byte otherwise.
- R6: With local connect on, the transmit channel number is `{B[0], A[6:0]}` and A[7] is ignored. The channel captures `tx_data` of that transmit channel in the frame-sync cycle. A number at or above the transmit channel count yields 0xFF.
- R7: Routing byte B bit 7 is the output enable. While it is 0, `rx_data` is 0xFF and `rx_valid` is 0. While it is 1, `rx_data` shows the handed-over byte, and `rx_valid` is 1 once the channel has handed over at least once since reset.
- R8: With the parallel source, a host write to register 3 sets the channel's sample. Bus and local capture no longer change it. Register 3 reads back the sample storage.
- R9: A host write to register 3 while the source is serial is dropped. The storage keeps the last serial capture, and that capture is what the channel delivers after a later switch to the parallel source.
- R10: If minimum delay and the parallel source are selected together, the channel hands over at frame sync as in constant mode. It also sets status bit 0, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timeslot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, high in the slot-0 cycle |
| slot_idx | input | SLOT_W | Current timeslot index |
| bus_in | input | NSTREAM*8 | Byte of every stream in the current timeslot, stream i at [8i+7:8i] |
| tx_data | input | NTX*8 | Transmit channel samples, channel i at [8i+7:8i] |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | CH_W+3 | Channel number and register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| rx_data | output | NCH*8 | Receive channel outputs, channel c at [8c+7:8c] |
| rx_valid | output | NCH | Per-channel valid flag |

## Verification
The assertions check on every cycle that a channel's output changes only at its handover edge for the switching mode in effect. They also check that the sample storage changes only through a capture or an allowed host write, and that the configuration error flag is set by the forbidden combination and then stays set. Only the bench scenarios can show that the right byte arrives. That covers the slot and stream routing, the frame-versus-slot latency for each input/output slot pairing, local transmit channel numbering including out-of-range numbers, the dropped write followed by a source switch, and the idle pattern under a disabled output.

// File: rtl/tdm_rxsw_pkg.sv
package tdm_rxsw_pkg;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    // control byte bits [2:0]: par_src is bit 2, loc_con bit 1, min_dly bit 0
    typedef struct packed {
        logic par_src;
        logic loc_con;
        logic min_dly;
    } chctl_t;

    typedef enum logic [2:0] {
        REG_CTL  = 3'd0,
        REG_RTA  = 3'd1,
        REG_RTB  = 3'd2,
        REG_PAR  = 3'd3,
        REG_STAT = 3'd4
    } regsel_e;

    function automatic logic [7:0] loc_txnum(input logic [7:0] rta, input logic [7:0] rtb);
        return {rtb[0], rta[6:0]};
    endfunction

endpackage

// File: rtl/tdm_rxsw_capsel.sv
module tdm_rxsw_capsel
    import tdm_rxsw_pkg::*;
#(
    parameter int NSTREAM = 2,
    parameter int NTX     = 4,
    parameter int SLOT_W  = 3,
    parameter int STRM_W  = 1
) (
    input  logic                 loc_con,
    input  logic [7:0]           rta,
    input  logic [7:0]           rtb,
    input  logic                 fsync,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [NSTREAM*8-1:0] bus_in,
    input  logic [NTX*8-1:0]     tx_data,
    output logic                 cap_en,
    output logic [7:0]           cap_byte
);

    logic [7:0]        txn;
    logic [STRM_W-1:0] strm;
    logic [7:0]        bus_byte;
    logic [7:0]        tx_byte;

    always_comb begin
        txn      = loc_txnum(rta, rtb);
        strm     = rtb[STRM_W-1:0];
        bus_byte = IDLE_BYTE;
        for (int i = 0; i < NSTREAM; i++) begin
            if (STRM_W'(i) == strm) bus_byte = bus_in[i*8 +: 8];
        end
        tx_byte = IDLE_BYTE;
        for (int i = 0; i < NTX; i++) begin
            if (8'(i) == txn) tx_byte = tx_data[i*8 +: 8];
        end
        cap_en   = loc_con ? fsync : (rta == 8'(slot_idx));
        cap_byte = loc_con ? tx_byte : bus_byte;
    end

endmodule

// File: rtl/tdm_rxsw_chan.sv
module tdm_rxsw_chan
    import tdm_rxsw_pkg::*;
#(
    parameter int CH      = 0,
    parameter int NSTREAM = 2,
    parameter int NTX     = 4,
    parameter int SLOT_W  = 3,
    parameter int STRM_W  = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fsync,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [NSTREAM*8-1:0] bus_in,
    input  logic [NTX*8-1:0]     tx_data,
    input  logic                 we,
    input  logic [2:0]           regsel,
    input  logic [7:0]           wdata,
    output logic [7:0]           rd_byte,
    output logic [7:0]           rx_data,
    output logic                 rx_valid
);

    chctl_t     ctl_q;
    logic [7:0] rta_q, rtb_q, store_q, out_q;
    logic       vld_q, cfg_err_q;
    logic       cap_en;
    logic [7:0] cap_byte;
    logic       eff_const, at_own, xfer, par_wr;

    tdm_rxsw_capsel #(
        .NSTREAM(NSTREAM), .NTX(NTX), .SLOT_W(SLOT_W), .STRM_W(STRM_W)
    ) u_capsel (
        .loc_con (ctl_q.loc_con),
        .rta     (rta_q),
        .rtb     (rtb_q),
        .fsync   (fsync),
        .slot_idx(slot_idx),
        .bus_in  (bus_in),
        .tx_data (tx_data),
        .cap_en  (cap_en),
        .cap_byte(cap_byte)
    );

    // the forbidden pairing of minimum delay and parallel source falls back to frame handover
    assign eff_const = !ctl_q.min_dly || ctl_q.par_src;
    assign at_own    = (32'(slot_idx) == CH);
    assign xfer      = eff_const ? fsync : at_own;
    assign par_wr    = we && (regsel == REG_PAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            rta_q     <= '0;
            rtb_q     <= '0;
            store_q   <= '0;
            out_q     <= '0;
            vld_q     <= 1'b0;
            cfg_err_q <= 1'b0;
        end else begin
            if (we && regsel == REG_CTL) ctl_q <= chctl_t'(wdata[2:0]);
            if (we && regsel == REG_RTA) rta_q <= wdata;
            if (we && regsel == REG_RTB) rtb_q <= wdata;
            if (ctl_q.par_src) begin
                if (par_wr) store_q <= wdata;
            end else if (cap_en) begin
                store_q <= cap_byte;
            end
            if (xfer) begin
                out_q <= store_q;
                vld_q <= 1'b1;
            end
            if (ctl_q.min_dly && ctl_q.par_src) cfg_err_q <= 1'b1;
        end
    end

    always_comb begin
        case (regsel)
            REG_CTL:  rd_byte = {5'b0, ctl_q};
            REG_RTA:  rd_byte = rta_q;
            REG_RTB:  rd_byte = rtb_q;
            REG_PAR:  rd_byte = store_q;
            REG_STAT: rd_byte = {7'b0, cfg_err_q};
            default:  rd_byte = 8'h00;
        endcase
    end

    assign rx_data  = rtb_q[7] ? out_q : IDLE_BYTE;
    assign rx_valid = rtb_q[7] & vld_q;

    // R4
    const_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(eff_const && !fsync) |-> $stable(out_q));

    // R5
    min_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!eff_const && !at_own) |-> $stable(out_q));

    // R8
    par_store_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_q.par_src && !par_wr) |-> $stable(store_q));

    // R9
    ser_store_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!ctl_q.par_src && !cap_en) |-> $stable(store_q));

    // R10
    cfg_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.min_dly && ctl_q.par_src) |=> cfg_err_q);

    // R10
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_err_q) |-> cfg_err_q);

endmodule

// File: rtl/tdm_rx_switch.sv
module tdm_rx_switch
    import tdm_rxsw_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int NSLOT   = 8,
    parameter int NSTREAM = 2,
    parameter int NTX     = 4,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int STRM_W = $clog2(NSTREAM),
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fsync,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [NSTREAM*8-1:0] bus_in,
    input  logic [NTX*8-1:0]     tx_data,
    input  logic                 host_we,
    input  logic [CH_W+2:0]      host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic [NCH*8-1:0]     rx_data,
    output logic [NCH-1:0]       rx_valid
);

    logic [7:0]      rd_bytes [NCH];
    logic [CH_W-1:0] sel_ch;

    assign sel_ch = host_addr[CH_W+2:3];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tdm_rxsw_chan #(
            .CH(c), .NSTREAM(NSTREAM), .NTX(NTX), .SLOT_W(SLOT_W), .STRM_W(STRM_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .fsync   (fsync),
            .slot_idx(slot_idx),
            .bus_in  (bus_in),
            .tx_data (tx_data),
            .we      (host_we && (32'(sel_ch) == c)),
            .regsel  (host_addr[2:0]),
            .wdata   (host_wdata),
            .rd_byte (rd_bytes[c]),
            .rx_data (rx_data[c*8 +: 8]),
            .rx_valid(rx_valid[c])
        );
    end

    always_comb begin
        host_rdata = 8'h00;
        for (int c = 0; c < NCH; c++) begin
            if (32'(sel_ch) == c) host_rdata = rd_bytes[c];
        end
    end

endmodule

// File: tb/tdm_rx_switch_test.sv
`timescale 1ns/1ps
module tdm_rx_switch_test;

    localparam int NCH = 4, NSLOT = 8, NSTREAM = 2, NTX = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               fsync = 1'b0;
    logic [2:0]         slot_idx = '0;
    logic [NSTREAM*8-1:0] bus_in = '0;
    logic [NTX*8-1:0]   tx_data = '0;
    logic               host_we = 1'b0;
    logic [4:0]         host_addr = '0;
    logic [7:0]         host_wdata = '0;
    logic [7:0]         host_rdata;
    logic [NCH*8-1:0]   rx_data;
    logic [NCH-1:0]     rx_valid;

    int n_cmp = 0, n_bad = 0, fr = 0, frz = NSLOT - 1;
    logic [7:0] rd;

    tdm_rx_switch #(.NCH(NCH), .NSLOT(NSLOT), .NSTREAM(NSTREAM), .NTX(NTX)) uut (.*);

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(int f, int sl, int st);
        return 8'((f * 37 + sl * 5 + st * 101 + 3) & 255);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drive_frozen();
        fsync = 1'b0; slot_idx = 3'(frz); bus_in = {NSTREAM{8'hEE}};
    endtask

    task automatic wr(int ch, int rs, logic [7:0] d);
        @(negedge clk); drive_frozen();
        host_we = 1'b1; host_addr = 5'(ch * 8 + rs); host_wdata = d;
        @(posedge clk); #1 host_we = 1'b0;
    endtask

    task automatic rdreg(int ch, int rs);
        @(negedge clk); drive_frozen();
        host_addr = 5'(ch * 8 + rs); #1 rd = host_rdata;
    endtask

    task automatic run_frame();
        for (int sl = 0; sl < NSLOT; sl++) begin
            @(negedge clk);
            fsync = (sl == 0); slot_idx = 3'(sl);
            for (int st = 0; st < NSTREAM; st++) bus_in[st*8 +: 8] = pat(fr, sl, st);
        end
        @(posedge clk); #1;
        fr++;
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NTX; i++) tx_data[i*8 +: 8] = 8'(17 * (i + 1));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            chk("R1 rx_data", rx_data[c*8 +: 8], 8'hFF);
            chk("R1 rx_valid", {7'b0, rx_valid[c]}, 8'h00);
            for (int rs = 0; rs < 5; rs++) begin
                rdreg(c, rs); chk("R1 register", rd, 8'h00);
            end
        end
        // R2 reserved control bits read zero
        wr(3, 0, 8'hFB); rdreg(3, 0); chk("R2 control readback", rd, 8'h03);
        // R3 R4 R5 sweep over input slot, stream and mode
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < NSLOT; k++)
                for (int s = 0; s < NSTREAM; s++) begin
                    for (int c = 0; c < NCH; c++) begin
                        wr(c, 0, 8'(m)); wr(c, 1, 8'(k)); wr(c, 2, 8'h80 | 8'(s));
                    end
                    run_frame(); run_frame();
                    for (int c = 0; c < NCH; c++) begin
                        logic [7:0] e;
                        e = (m == 1 && k < c) ? pat(fr - 1, k, s) : pat(fr - 2, k, s);
                        chk(m ? "R5 R3 min-delay routing" : "R4 R3 constant routing", rx_data[c*8 +: 8], e);
                        chk("R7 valid", {7'b0, rx_valid[c]}, 8'h01);
                    end
                end
        // R7 output enable low
        wr(1, 2, 8'h01);
        chk("R7 idle data", rx_data[15:8], 8'hFF);
        chk("R7 valid low", {7'b0, rx_valid[1]}, 8'h00);
        // R6 local connect
        wr(0, 0, 8'h02); wr(0, 1, 8'h03); wr(0, 2, 8'h80);
        wr(1, 0, 8'h02); wr(1, 1, 8'h02); wr(1, 2, 8'h81);
        wr(2, 0, 8'h03); wr(2, 1, 8'h01); wr(2, 2, 8'h80);
        wr(3, 0, 8'h02); wr(3, 1, 8'h80); wr(3, 2, 8'h80);
        run_frame(); run_frame();
        chk("R6 local tx3", rx_data[7:0], 8'h44);
        chk("R6 local out of range", rx_data[15:8], 8'hFF);
        chk("R6 local tx1 min", rx_data[23:16], 8'h22);
        chk("R6 local A7 ignored", rx_data[31:24], 8'h11);
        // R9 dropped parallel write while serial, then source switch
        wr(1, 0, 8'h00); wr(1, 1, 8'h02); wr(1, 2, 8'h81);
        run_frame(); run_frame();
        wr(1, 3, 8'hA5);
        rdreg(1, 3); chk("R9 write dropped", rd, pat(fr - 1, 2, 1));
        wr(1, 0, 8'h04);
        run_frame(); run_frame();
        chk("R9 last capture delivered", rx_data[15:8], pat(fr - 3, 2, 1));
        // R8 parallel source
        wr(1, 3, 8'h3C);
        rdreg(1, 3); chk("R8 parallel readback", rd, 8'h3C);
        run_frame(); run_frame();
        chk("R8 parallel delivered", rx_data[15:8], 8'h3C);
        // R10 min delay with parallel source
        wr(2, 0, 8'h04); wr(2, 3, 8'h5D);
        run_frame();
        chk("R10 setup", rx_data[23:16], 8'h5D);
        frz = 2;
        wr(2, 0, 8'h05); wr(2, 3, 8'h77);
        repeat (3) begin @(negedge clk); drive_frozen(); end
        @(posedge clk); #1;
        chk("R10 no slot handover", rx_data[23:16], 8'h5D);
        rdreg(2, 4); chk("R10 error flag", rd, 8'h01);
        wr(2, 0, 8'h04);
        rdreg(2, 4); chk("R10 error sticky", rd, 8'h01);
        rdreg(3, 4); chk("R10 other channel clean", rd, 8'h00);
        frz = NSLOT - 1;
        run_frame();
        chk("R10 frame handover", rx_data[23:16], 8'h77);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule